// File: doc/BRIEF.md
# Multi-Cycle 32-bit RISC Core

This block is a small, non-pipelined processor for a 32-bit load/store instruction subset. A single control state machine steps each instruction through fetch, decode with register read, execute or address generation, memory access or branch resolution, and result write-back. Values that pass between steps are held in a fixed set of internal registers: instruction, next PC, operand A, operand B, extended immediate, ALU result and load data. An instruction uses only the steps it needs, so its length is 3, 4 or 5 cycles.

A single word-addressed memory port serves both instruction fetch and data access. The port returns read data in the same cycle the address is presented and commits a write at the clock edge that ends a cycle in which the write strobe is high. A combinational debug port reads any register of the 32-entry register file. Control and datapath are separate modules. The control passes a small packed struct of strobes to the datapath.

Top module: `mcpu_core`

## Requirements
- R1: A synchronous active-high reset sets PC to 0, clears all registers and selects the fetch step. While reset is held, memAddr is 0 and memWe is 0.
- R2: Instruction fields are opcode [31:26], source s [25:21], source/target t [20:16], destination d [15:11], function [5:0] and immediate [15:0]. The immediate is always sign-extended to 32 bits.
- R3: Opcode 0x00 is a register-register operation taking 4 cycles, with d <= s OP t. The function codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR and 5 signed less-than (result 1 or 0). Any other function code writes 0.
- R4: Opcodes 0x01 add, 0x02 AND, 0x03 OR and 0x04 signed less-than are register-immediate operations taking 4 cycles, with t <= s OP immediate.
- R5: Opcode 0x08 is a load taking 5 cycles: t <= mem[s + immediate]. The data address appears on memAddr in the instruction's fourth cycle.
- R6: Opcode 0x09 is a store taking 4 cycles: mem[s + immediate] <= t. memWe is high only in the fourth cycle of a store, and a store changes no register.
- R7: Opcode 0x0C is a branch taking 4 cycles. If register s equals zero, PC becomes PC + 4 + immediate, with the immediate used as a byte offset. Otherwise PC becomes PC + 4. A branch writes no register and no memory.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: Any other opcode takes 3 cycles, writes no register and no memory, and advances PC by 4.
- R10: memAddr carries byte-address bits [ADDR_W+1:2]: PC during fetch and the computed data address during a memory access. The two low bits of the byte address are dropped.
- R11: dbgData shows the register selected by dbgAddr combinationally.
- R12: PC changes only at the end of an instruction's last cycle, and each fetch follows the previous instruction's last cycle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | ADDR_W | Word address of the memory access |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Read data for memAddr, valid in the same cycle |
| dbgAddr | input | 5 | Debug register select |
| dbgData | output | 32 | Debug register value |

## Verification
On every cycle the assertions check several things. Fetch is always followed by decode and decode by execute. PC holds between load strobes and lands on the computed target when a branch is taken. The next-PC register is PC plus four after each fetch. Only stores raise the write strobe, and only result-producing opcodes write the register file. The bench's reference model covers the rest. It places every fetch address in the predicted cycle, which exposes wrong instruction lengths. It also shows correct ALU results, sign extension, register-zero behaviour, dropped address bits, and memory contents after stores. The bench follows branch direction and loop exits by running a small program.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 6;

  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h01;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h02;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h03;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'h04;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h08;
  localparam logic [OP_W-1:0] OP_STORE = 6'h09;
  localparam logic [OP_W-1:0] OP_BEQZ  = 6'h0C;

  localparam logic [5:0] FN_ADD = 6'd0;
  localparam logic [5:0] FN_SUB = 6'd1;
  localparam logic [5:0] FN_AND = 6'd2;
  localparam logic [5:0] FN_OR  = 6'd3;
  localparam logic [5:0] FN_XOR = 6'd4;
  localparam logic [5:0] FN_SLT = 6'd5;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} phase_e;
  typedef enum logic [1:0] {ALU_ADDR, ALU_BRANCH, ALU_REG, ALU_IMM} aluMode_e;
  typedef enum logic [2:0] {CL_REG, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH, CL_OTHER} class_e;
  typedef enum logic [2:0] {K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLT, K_ZERO} aluKind_e;

  typedef struct packed {
    logic     irLoad;
    logic     opLoad;
    logic     aluLoad;
    logic     lmdLoad;
    logic     memWrite;
    logic     dataAddr;
    logic     pcLoad;
    logic     pcBranch;
    logic     regWrite;
    logic     wbFromLoad;
    logic     wbToRd;
    aluMode_e aluMode;
  } ctrl_t;

  function automatic class_e classify(logic [OP_W-1:0] op);
    case (op)
      OP_REG:                             return CL_REG;
      OP_ADDI, OP_ANDI, OP_ORI, OP_SLTI:  return CL_IMM;
      OP_LOAD:                            return CL_LOAD;
      OP_STORE:                           return CL_STORE;
      OP_BEQZ:                            return CL_BRANCH;
      default:                            return CL_OTHER;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] aluEval(aluKind_e k, logic [WORD_W-1:0] x,
                                                logic [WORD_W-1:0] y);
    case (k)
      K_ADD:   return x + y;
      K_SUB:   return x - y;
      K_AND:   return x & y;
      K_OR:    return x | y;
      K_XOR:   return x ^ y;
      K_SLT:   return {{(WORD_W-1){1'b0}}, $signed(x) < $signed(y)};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  input  logic [IW-1:0] rdIdxA,
  input  logic [IW-1:0] rdIdxB,
  input  logic [IW-1:0] rdIdxC,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  output logic [DW-1:0] rdDataC
);
  logic [DW-1:0] view [NREG];

  // entry 0 has no storage: it is wired to zero
  assign view[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : gReg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                          q <= '0;
      else if (wrEn && wrIdx == IW'(g)) q <= wrData;
    end
    assign view[g] = q;
  end

  assign rdDataA = view[rdIdxA];
  assign rdDataB = view[rdIdxB];
  assign rdDataC = view[rdIdxC];
endmodule

// File: rtl/mcpu_control.sv
module mcpu_control
  import mcpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl
);
  phase_e phaseQ, phaseD;
  class_e cls;

  assign cls = classify(opcode);

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= ST_FETCH;
    else     phaseQ <= phaseD;
  end

  always_comb begin
    ctrl   = '0;
    phaseD = ST_FETCH;
    case (phaseQ)
      ST_FETCH: begin
        ctrl.irLoad = 1'b1;
        phaseD      = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl.opLoad = 1'b1;
        phaseD      = ST_EXEC;
      end
      ST_EXEC: begin
        ctrl.aluLoad = 1'b1;
        case (cls)
          CL_REG:    begin ctrl.aluMode = ALU_REG;    phaseD = ST_WB;  end
          CL_IMM:    begin ctrl.aluMode = ALU_IMM;    phaseD = ST_WB;  end
          CL_LOAD,
          CL_STORE:  begin ctrl.aluMode = ALU_ADDR;   phaseD = ST_MEM; end
          CL_BRANCH: begin ctrl.aluMode = ALU_BRANCH; phaseD = ST_MEM; end
          default:   begin ctrl.pcLoad  = 1'b1;       phaseD = ST_FETCH; end
        endcase
      end
      ST_MEM: begin
        ctrl.dataAddr = 1'b1;
        case (cls)
          CL_LOAD:   begin ctrl.lmdLoad = 1'b1; phaseD = ST_WB; end
          CL_STORE:  begin ctrl.memWrite = 1'b1; ctrl.pcLoad = 1'b1; end
          CL_BRANCH: begin ctrl.pcLoad = 1'b1; ctrl.pcBranch = 1'b1; end
          default:   ctrl.pcLoad = 1'b1;
        endcase
      end
      ST_WB: begin
        ctrl.regWrite   = 1'b1;
        ctrl.wbFromLoad = (cls == CL_LOAD);
        ctrl.wbToRd     = (cls == CL_REG);
        ctrl.pcLoad     = 1'b1;
      end
      default: phaseD = ST_FETCH;
    endcase
  end

  // R12: the first three steps always follow one another
  assert_fetch_to_decode_R12: assert property (@(posedge clk) disable iff (rst)
    phaseQ == ST_FETCH |=> phaseQ == ST_DECODE);
  assert_decode_to_exec_R12: assert property (@(posedge clk) disable iff (rst)
    phaseQ == ST_DECODE |=> phaseQ == ST_EXEC);
endmodule

// File: rtl/mcpu_datapath.sv
module mcpu_datapath
  import mcpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 32,
  localparam int IW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [IW-1:0]     dbgAddr,
  output logic [WORD_W-1:0] dbgData
);
  logic [WORD_W-1:0] pc, npc, ir, regA, regB, immX, aluOut, lmd;
  logic              condQ;
  logic [IW-1:0]     rsIdx, rtIdx, rdIdx, wrIdx;
  logic [5:0]        funct;
  logic [WORD_W-1:0] immExt, rfA, rfB, aluRes, wrData;
  aluKind_e          regKind, immKind;
  logic              unusedShamt;

  assign opcode      = ir[31:26];
  assign rsIdx       = ir[25:21];
  assign rtIdx       = ir[20:16];
  assign rdIdx       = ir[15:11];
  assign funct       = ir[5:0];
  assign unusedShamt = ^ir[10:6];
  assign immExt      = {{(WORD_W-16){ir[15]}}, ir[15:0]};

  always_comb begin
    case (funct)
      FN_ADD:  regKind = K_ADD;
      FN_SUB:  regKind = K_SUB;
      FN_AND:  regKind = K_AND;
      FN_OR:   regKind = K_OR;
      FN_XOR:  regKind = K_XOR;
      FN_SLT:  regKind = K_SLT;
      default: regKind = K_ZERO;
    endcase
    case (opcode)
      OP_ANDI: immKind = K_AND;
      OP_ORI:  immKind = K_OR;
      OP_SLTI: immKind = K_SLT;
      default: immKind = K_ADD;
    endcase
    case (ctrl.aluMode)
      ALU_ADDR:   aluRes = aluEval(K_ADD, regA, immX);
      ALU_BRANCH: aluRes = aluEval(K_ADD, npc, immX);
      ALU_REG:    aluRes = aluEval(regKind, regA, regB);
      default:    aluRes = aluEval(immKind, regA, immX);
    endcase
  end

  assign wrIdx  = ctrl.wbToRd ? rdIdx : rtIdx;
  assign wrData = ctrl.wbFromLoad ? lmd : aluOut;

  mcpu_regfile #(.NREG(NREG), .DW(WORD_W)) uRegs (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (ctrl.regWrite),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .rdIdxA  (rsIdx),
    .rdIdxB  (rtIdx),
    .rdIdxC  (dbgAddr),
    .rdDataA (rfA),
    .rdDataB (rfB),
    .rdDataC (dbgData)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      npc    <= '0;
      ir     <= '0;
      regA   <= '0;
      regB   <= '0;
      immX   <= '0;
      aluOut <= '0;
      lmd    <= '0;
      condQ  <= 1'b0;
    end else begin
      if (ctrl.irLoad) begin
        ir  <= memRdata;
        npc <= pc + WORD_W'(4);
      end
      if (ctrl.opLoad) begin
        regA <= rfA;
        regB <= rfB;
        immX <= immExt;
      end
      if (ctrl.aluLoad) begin
        aluOut <= aluRes;
        condQ  <= (regA == '0);
      end
      if (ctrl.lmdLoad) lmd <= memRdata;
      if (ctrl.pcLoad)  pc  <= (ctrl.pcBranch && condQ) ? aluOut : npc;
    end
  end

  assign memAddr  = ctrl.dataAddr ? aluOut[ADDR_W+1:2] : pc[ADDR_W+1:2];
  assign memWe    = ctrl.memWrite;
  assign memWdata = regB;

  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pcLoad |=> $stable(pc));
  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pcLoad && ctrl.pcBranch && condQ) |=> pc == $past(aluOut));
  assert_next_pc_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl.irLoad |=> npc == $past(pc) + WORD_W'(4));
  assert_store_only_R6: assert property (@(posedge clk) disable iff (rst)
    memWe |-> opcode == OP_STORE);
  assert_regwrite_class_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.regWrite |-> (opcode == OP_REG || opcode == OP_LOAD ||
                       (opcode >= OP_ADDI && opcode <= OP_SLTI)));
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic [4:0]        dbgAddr,
  output logic [31:0]       dbgData
);
  ctrl_t           ctrl;
  logic [OP_W-1:0] opcode;

  mcpu_control uCtrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  mcpu_datapath #(.ADDR_W(ADDR_W), .NREG(32)) uData (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData)
  );
endmodule

// File: tb/mcpu_core_test.sv
`timescale 1ns/1ps
module mcpu_core_test;
  localparam int AW    = 8;
  localparam int WORDS = 1 << AW;
  localparam int NCYC  = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] memAddr;
  logic          memWe;
  logic [31:0]   memWdata, memRdata, dbgData;
  logic [4:0]    dbgAddr = '0;

  logic [31:0] mem    [WORDS];
  logic [31:0] refMem [WORDS];
  logic [31:0] refRegs[32];
  string       tagOf  [WORDS];

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mcpu_core #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .dbgAddr(dbgAddr), .dbgData(dbgData));

  assign memRdata = mem[memAddr];
  always @(posedge clk) if (!rst && memWe) mem[memAddr] <= memWdata;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_rr(input int fn, input int d, input int s, input int t);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int t, input int s, input int imm);
    return {6'(op), 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic int lenOf(input logic [5:0] op);
    if (op == 6'h08) return 5;
    if (op <= 6'h04 || op == 6'h09 || op == 6'h0C) return 4;
    return 3;
  endfunction

  task automatic put(input int idx, input logic [31:0] w, input string tag);
    mem[idx] = w; refMem[idx] = w; tagOf[idx] = tag;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] refPc, refIr, imm, eff, a, b, res;
    logic [5:0]  op;
    int phase, pendReg, pendMem, s, t, d, dest;
    string curTag, prevTag;

    for (int i = 0; i < WORDS; i++) put(i, 32'hA500_0000 + 32'(i), "");
    put(0,  enc_i(1, 1, 0, 5),         "R4");
    put(1,  enc_i(1, 2, 0, -3),        "R2");
    put(2,  enc_rr(0, 3, 1, 2),        "R3");
    put(3,  enc_rr(1, 4, 1, 2),        "R3");
    put(4,  enc_rr(2, 5, 1, 2),        "R3");
    put(5,  enc_rr(3, 6, 1, 2),        "R3");
    put(6,  enc_rr(4, 7, 1, 2),        "R3");
    put(7,  enc_rr(5, 8, 2, 1),        "R3");
    put(8,  enc_i(2, 9, 2, 16'h00F0),  "R4");
    put(9,  enc_i(3, 10, 0, 16'h8000), "R2");
    put(10, enc_i(4, 11, 2, 0),        "R4");
    put(11, enc_i(1, 0, 0, 7),         "R8");
    put(12, enc_rr(0, 12, 0, 1),       "R8");
    put(13, enc_i(9, 4, 0, 16'h0100),  "R6");
    put(14, enc_i(1, 20, 0, 16'h0120), "R4");
    put(15, enc_i(9, 2, 20, -8),       "R6");
    put(16, enc_i(8, 13, 0, 16'h0100), "R5");
    put(17, enc_i(8, 14, 1, 16'h0113), "R10");
    put(18, enc_i(12, 0, 0, 8),        "R7");
    put(19, enc_i(1, 15, 0, 99),       "R7");
    put(20, enc_i(1, 15, 0, 98),       "R7");
    put(21, enc_i(12, 0, 1, 8),        "R7");
    put(22, {6'h3F, 26'd0},            "R9");
    put(23, enc_rr(7, 17, 1, 1),       "R3");
    put(24, enc_i(1, 16, 0, 3),        "R4");
    put(25, enc_i(1, 16, 16, -1),      "R12");
    put(26, enc_i(12, 0, 16, 4),       "R7");
    put(27, enc_i(12, 0, 0, -12),      "R7");
    put(28, enc_i(8, 18, 0, 0),        "R5");
    put(29, enc_i(12, 0, 0, -4),       "R7");
    for (int r = 0; r < 32; r++) refRegs[r] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "memAddr in reset", 32'(memAddr), 32'd0);
    check("R1", "memWe in reset", 32'(memWe), 32'd0);
    dbgAddr = 5'd1; #1;
    check("R1", "reg1 after reset", dbgData, 32'd0);
    rst = 1'b0;

    refPc = '0; refIr = '0; phase = 0; pendReg = -1; pendMem = -1;
    curTag = "R1"; prevTag = "R1";
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (pendReg >= 0) begin
        dbgAddr = 5'(pendReg); #1;
        check(prevTag, $sformatf("reg%0d", pendReg), dbgData, refRegs[pendReg]);
        pendReg = -1;
      end
      if (pendMem >= 0) begin
        check(prevTag, $sformatf("mem[%0d]", pendMem), mem[pendMem], refMem[pendMem]);
        pendMem = -1;
      end
      if (phase == 0) begin
        refIr  = refMem[refPc[AW+1:2]];
        curTag = tagOf[refPc[AW+1:2]];
        check({prevTag, "/R12"}, "fetch address", 32'(memAddr), 32'(refPc[AW+1:2]));
      end
      op  = refIr[31:26];
      s   = int'(refIr[25:21]);
      t   = int'(refIr[20:16]);
      d   = int'(refIr[15:11]);
      imm = sext(refIr[15:0]);
      a   = refRegs[s];
      b   = refRegs[t];
      eff = a + imm;
      if (phase == 3 && (op == 6'h08 || op == 6'h09))
        check({curTag, "/R10"}, "data address", 32'(memAddr), 32'(eff[AW+1:2]));
      check("R6", "write strobe", 32'(memWe), 32'((phase == 3 && op == 6'h09) ? 1 : 0));
      if (phase == 3 && op == 6'h09) check("R6", "store data", memWdata, b);

      if (phase == lenOf(op) - 1) begin
        dest = -1; res = '0;
        if (op == 6'h00) begin
          dest = d;
          case (refIr[5:0])
            6'd0: res = a + b;
            6'd1: res = a - b;
            6'd2: res = a & b;
            6'd3: res = a | b;
            6'd4: res = a ^ b;
            6'd5: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: res = '0;
          endcase
        end else if (op >= 6'h01 && op <= 6'h04) begin
          dest = t;
          case (op)
            6'h01: res = a + imm;
            6'h02: res = a & imm;
            6'h03: res = a | imm;
            default: res = ($signed(a) < $signed(imm)) ? 32'd1 : 32'd0;
          endcase
        end else if (op == 6'h08) begin
          dest = t; res = refMem[eff[AW+1:2]];
        end else if (op == 6'h09) begin
          refMem[eff[AW+1:2]] = b; pendMem = int'(eff[AW+1:2]);
        end
        if (dest > 0) refRegs[dest] = res;
        if (dest >= 0) pendReg = dest;
        if (op == 6'h0C && a == 0) refPc = refPc + 32'd4 + imm;
        else                       refPc = refPc + 32'd4;
        phase = 0;
        prevTag = curTag;
      end else begin
        phase++;
      end
    end

    @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      dbgAddr = 5'(r); #0.1;
      check("R11", $sformatf("final reg%0d", r), dbgData, refRegs[r]);
    end
    for (int i = 0; i < WORDS; i++)
      if (mem[i] !== refMem[i]) check("R6", $sformatf("final mem[%0d]", i), mem[i], refMem[i]);
    check("R8", "reg0 via debug", refRegs[0], 32'd0);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule